// File: doc/BRIEF.md
# Transpose Address Generator for Radar Data Cubes

This block sequences the addresses for rearranging radar data held in external SDRAM, so that each FFT stage that follows reads its input from consecutive words. One start command runs one full reorder. The block emits a stream of read and write word address pairs. Each pair says that the element at the read address must be stored at the write address. It does not move any data itself.

Two reorders are available. The corner turn takes a chirp-by-sample matrix and stores it sample-major. The cube rotation takes an antenna-by-range-by-chirp cube and stores it range-by-chirp-by-antenna, so that the antenna index varies fastest.

Reads always walk the source in linear order. Each pair also carries a flag that is high when its read address lies in a different SDRAM row than the previous read. A running count of these flags lets the row-open cost of a reorder be measured. The mode and both base addresses are captured when the start is accepted, so one block can serve every antenna's matrix in turn.

Top module: `tr_addr_gen`

## Requirements
- R1: After a synchronous reset, `busy`, `out_valid` and `done` are 0 and `row_cnt` is 0.
- R2: Corner turn (`mode`=0) runs over a matrix of N_CHIRP rows and N_SAMP columns. The k-th accepted pair has `rd_addr` = src_base + k and `wr_addr` = dst_base + s·N_CHIRP + c, where c = k / N_SAMP and s = k mod N_SAMP.
- R3: Cube rotation (`mode`=1) runs over a cube with N_ANT, N_RANGE and N_CHIRP as its dimensions. The k-th accepted pair has `rd_addr` = src_base + k and `wr_addr` = dst_base + (r·N_CHIRP + c)·N_ANT + a. Here a = k / (N_RANGE·N_CHIRP), r = (k / N_CHIRP) mod N_RANGE and c = k mod N_CHIRP.
- R4: A pair is accepted only in a cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, both addresses hold, and `out_valid` stays 1 into the next cycle.
- R5: After the last pair is accepted, `done` is 1 for exactly one cycle, in the cycle that follows the acceptance. `busy` and `out_valid` are 0 in that cycle. The last pair is number N_SAMP·N_CHIRP for the corner turn and N_ANT·N_RANGE·N_CHIRP for the cube rotation.
- R6: A `start` is accepted only when `busy` is 0. A `start` during a run, including one in the cycle of its last acceptance, leaves the pair sequence unchanged.
- R7: `row_chg` is 1 on the first pair of a run. After that, it is 1 exactly when `rd_addr` >> ROW_LOG2 differs from the same field of the previously accepted read address.
- R8: `row_cnt` counts the accepted pairs that had `row_chg` = 1. It is cleared when a start is accepted and holds its value after `done`.
- R9: `mode`, `src_base` and `dst_base` are sampled only when a start is accepted. Changing them during a run does not alter any address that run produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reorder (accepted when idle) |
| mode | input | 1 | 0 = corner turn, 1 = cube rotation |
| src_base | input | AW | Word address of the source array |
| dst_base | input | AW | Word address of the destination array |
| busy | output | 1 | A reorder is in progress |
| done | output | 1 | One-cycle pulse after the last pair is accepted |
| out_valid | output | 1 | Address pair available |
| out_ready | input | 1 | Consumer takes the pair this cycle |
| rd_addr | output | AW | Source word address of the pair |
| wr_addr | output | AW | Destination word address of the pair |
| row_chg | output | 1 | Read address enters a new SDRAM row |
| row_cnt | output | CNT_W | Row changes counted in the current run |

## Verification
Two events can land in the same cycle. The first is the acceptance of the final pair together with a fresh `start`. That start must be dropped, and the bench provokes this case with random start pulses throughout every run. The second is the `done` cycle together with a fresh `start`, which must be taken. A directed case raises `start` in exactly that cycle and expects `busy` in the next cycle, with `row_cnt` restarting from zero. Around both events, every pair, the row-change flag and the final count are compared with values computed from the index formulas in the bench.

// File: rtl/tr_pkg.sv
package tr_pkg;

    typedef enum logic [0:0] {
        MODE_TURN = 1'b0,
        MODE_ROT  = 1'b1
    } tr_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tr_state_e;

    // ((hi * n_mid) + mid) * n_lo + lo
    function automatic logic [31:0] lin3(
        input logic [31:0] hi,
        input logic [31:0] mid,
        input logic [31:0] lo,
        input logic [31:0] n_mid,
        input logic [31:0] n_lo
    );
        return ((hi * n_mid) + mid) * n_lo + lo;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tr_idx_ctr.sv
module tr_idx_ctr #(
    parameter int IW = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                step,
    input  logic [2:0][IW-1:0]  lim,
    output logic [2:0][IW-1:0]  idx,
    output logic                last
);
    logic [2:0] wrap;
    logic [3:0] carry;

    assign carry[3] = step;

    for (genvar d = 2; d >= 0; d--) begin : g_digit
        assign wrap[d]  = (idx[d] == lim[d] - 1'b1);
        assign carry[d] = carry[d+1] && wrap[d];

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                idx[d] <= '0;
            end else if (carry[d+1]) begin
                idx[d] <= wrap[d] ? '0 : idx[d] + 1'b1;
            end
        end

        p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
            !clr |=> (idx[d] < lim[d]));
    end

    assign last = &wrap;

endmodule

// File: rtl/tr_addr_map.sv
module tr_addr_map
    import tr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int IW      = 11,
    parameter int N_CHIRP = 32,
    parameter int N_SAMP  = 1024,
    parameter int N_ANT   = 12,
    parameter int N_RANGE = 512
) (
    input  tr_mode_e            mode,
    input  logic [AW-1:0]       src_base,
    input  logic [AW-1:0]       dst_base,
    input  logic [2:0][IW-1:0]  idx,
    output logic [AW-1:0]       rd_addr,
    output logic [AW-1:0]       wr_addr
);
    logic [31:0] i0, i1, i2;
    logic [31:0] src_off, dst_off;

    assign i0 = 32'(idx[0]);
    assign i1 = 32'(idx[1]);
    assign i2 = 32'(idx[2]);

    always_comb begin
        if (mode == MODE_TURN) begin
            // i1 = chirp, i2 = sample
            src_off = lin3(32'd0, i1, i2, 32'(N_CHIRP), 32'(N_SAMP));
            dst_off = lin3(32'd0, i2, i1, 32'(N_SAMP), 32'(N_CHIRP));
        end else begin
            // i0 = antenna, i1 = range, i2 = chirp
            src_off = lin3(i0, i1, i2, 32'(N_RANGE), 32'(N_CHIRP));
            dst_off = lin3(i1, i2, i0, 32'(N_CHIRP), 32'(N_ANT));
        end
    end

    assign rd_addr = src_base + AW'(src_off);
    assign wr_addr = dst_base + AW'(dst_off);

endmodule

// File: rtl/tr_row_track.sv
module tr_row_track #(
    parameter int RW    = 22,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc,
    input  logic [RW-1:0]    row,
    output logic             flag,
    output logic [CNT_W-1:0] cnt
);
    logic          first_q;
    logic [RW-1:0] prev_q;

    assign flag = first_q || (row != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b1;
            prev_q  <= '0;
            cnt     <= '0;
        end else if (clr) begin
            first_q <= 1'b1;
            cnt     <= '0;
        end else if (acc) begin
            first_q <= 1'b0;
            prev_q  <= row;
            if (flag) cnt <= cnt + 1'b1;
        end
    end

    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(acc && flag)) |=> $stable(cnt));

    p_first_flag_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> flag);

    p_same_row_r7: assert property (@(posedge clk) disable iff (rst)
        (acc && !clr) |=> (flag || (row == $past(row)) || $past(clr)) );

endmodule

// File: rtl/tr_addr_gen.sv
module tr_addr_gen
    import tr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CNT_W    = 20,
    parameter int N_CHIRP  = 32,
    parameter int N_SAMP   = 1024,
    parameter int N_ANT    = 12,
    parameter int N_RANGE  = 512,
    parameter int ROW_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    output logic             busy,
    output logic             done,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [AW-1:0]    rd_addr,
    output logic [AW-1:0]    wr_addr,
    output logic             row_chg,
    output logic [CNT_W-1:0] row_cnt
);
    localparam int unsigned MAXD = max2(max2(N_CHIRP, N_SAMP), max2(N_ANT, N_RANGE));
    localparam int IW = $clog2(MAXD) + 1;
    localparam int RW = AW - ROW_LOG2;

    tr_state_e          state_q;
    tr_mode_e           mode_q;
    logic [AW-1:0]      sb_q, db_q;
    logic [2:0][IW-1:0] lim, idx;
    logic               last, acc, start_acc;

    assign start_acc = start && (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_RUN);
    assign busy      = out_valid;
    assign acc       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_TURN;
            sb_q    <= '0;
            db_q    <= '0;
            done    <= 1'b0;
        end else begin
            done <= acc && last;
            if (start_acc) begin
                state_q <= ST_RUN;
                mode_q  <= tr_mode_e'(mode);
                sb_q    <= src_base;
                db_q    <= dst_base;
            end else if (acc && last) begin
                state_q <= ST_IDLE;
            end
        end
    end

    always_comb begin
        if (mode_q == MODE_TURN) begin
            lim = {IW'(N_SAMP), IW'(N_CHIRP), IW'(1)};
        end else begin
            lim = {IW'(N_CHIRP), IW'(N_RANGE), IW'(N_ANT)};
        end
    end

    tr_idx_ctr #(.IW(IW)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_acc),
        .step (acc),
        .lim  (lim),
        .idx  (idx),
        .last (last)
    );

    tr_addr_map #(
        .AW(AW), .IW(IW), .N_CHIRP(N_CHIRP), .N_SAMP(N_SAMP),
        .N_ANT(N_ANT), .N_RANGE(N_RANGE)
    ) u_map (
        .mode     (mode_q),
        .src_base (sb_q),
        .dst_base (db_q),
        .idx      (idx),
        .rd_addr  (rd_addr),
        .wr_addr  (wr_addr)
    );

    tr_row_track #(.RW(RW), .CNT_W(CNT_W)) u_row (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_acc),
        .acc  (acc),
        .row  (rd_addr[AW-1:ROW_LOG2]),
        .flag (row_chg),
        .cnt  (row_cnt)
    );

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(rd_addr) && $stable(wr_addr)));

    p_read_linear_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && !last) |=> (rd_addr == $past(rd_addr) + 1'b1));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !(acc && last)) |=> busy);

endmodule

// File: tb/sim_tr_addr_gen.sv
module sim_tr_addr_gen;

    localparam int AW = 16, CW = 8;
    localparam int NC = 4, NS = 8, NA = 3, NR = 5, RL = 3;

    logic          clk = 1'b0, rst = 1'b1, start = 1'b0, mode = 1'b0, out_ready = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic          busy, done, out_valid, row_chg;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [CW-1:0] row_cnt;

    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    tr_addr_gen #(
        .AW(AW), .CNT_W(CW), .N_CHIRP(NC), .N_SAMP(NS),
        .N_ANT(NA), .N_RANGE(NR), .ROW_LOG2(RL)
    ) u0 (.*);

    task automatic chk(input string req, input int act, input int exp_v);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    function automatic int exp_wr(input int m, input int db, input int k);
        if (m == 0) return db + (k % NS) * NC + (k / NS);
        return db + (((k / NC) % NR) * NC + (k % NC)) * NA + (k / (NR * NC));
    endfunction

    // One full reorder; ready_pct sets the handshake density.
    task automatic run_xfer(input int m, input int sb, input int db,
                            input int ready_pct, input bit restart_in_done);
        int total, k, rows, prev_row, hold_rd, hold_wr;
        bit first, held;
        total = (m == 0) ? NC * NS : NA * NR * NC;
        k = 0; rows = 0; prev_row = 0; first = 1; held = 0;
        hold_rd = 0; hold_wr = 0;
        mode = m[0]; src_base = AW'(sb); dst_base = AW'(db); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy after start", int'(busy), 1);
        while (k < total) begin
            out_ready = (($urandom % 100) < ready_pct);
            // R9: disturb captured inputs; R6: stray starts
            mode = $urandom % 2;
            src_base = AW'($urandom);
            dst_base = AW'($urandom);
            start = ($urandom % 4) == 0;
            #1;
            if (held) begin
                chk("R4 hold rd", int'(rd_addr), hold_rd);
                chk("R4 hold wr", int'(wr_addr), hold_wr);
            end
            chk("R4 valid", int'(out_valid), 1);
            if (out_ready) begin
                int row_now;
                bit fexp;
                row_now = (sb + k) >> RL;
                fexp = first || (row_now != prev_row);
                chk(m == 0 ? "R2 rd" : "R3 rd", int'(rd_addr), (sb + k) & 16'hFFFF);
                chk(m == 0 ? "R2 wr" : "R3 wr", int'(wr_addr), exp_wr(m, db, k) & 16'hFFFF);
                chk("R7 row_chg", int'(row_chg), int'(fexp));
                if (fexp) rows++;
                prev_row = row_now; first = 0; held = 0; k++;
            end else begin
                held = 1; hold_rd = int'(rd_addr); hold_wr = int'(wr_addr);
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        start = restart_in_done;
        mode = 1'b0; src_base = '0; dst_base = 16'h0100;
        #1;
        chk("R5 done", int'(done), 1);
        chk("R5 busy low", int'(busy), 0);
        chk("R5 valid low", int'(out_valid), 0);
        chk("R8 row_cnt", int'(row_cnt), rows);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R5 done one cycle", int'(done), 0);
        if (restart_in_done) begin
            chk("R6 start in done cycle taken", int'(busy), 1);
            chk("R8 cleared at start", int'(row_cnt), 0);
            chk("R2 first rd", int'(rd_addr), 0);
            chk("R2 first wr", int'(wr_addr), 16'h0100);
            chk("R7 first flag", int'(row_chg), 1);
            out_ready = 1'b1;
            for (int j = 0; j < NC * NS; j++) @(negedge clk);
            out_ready = 1'b0;
            #1;
            chk("R8 aligned corner turn rows", int'(row_cnt), NC * NS / (1 << RL));
            @(negedge clk);
        end else begin
            chk("R8 held after done", int'(row_cnt), rows);
            chk("R6 stays idle", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 busy", int'(busy), 0);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 row_cnt", int'(row_cnt), 0);
        @(negedge clk);
        // directed: aligned, full rate
        run_xfer(0, 0, 16'h0400, 100, 1'b0);
        run_xfer(1, 16'h0200, 16'h0800, 100, 1'b0);
        // unaligned bases, sparse ready
        run_xfer(0, 16'h0005, 16'h0033, 40, 1'b0);
        run_xfer(1, 16'h0013, 16'h0107, 30, 1'b0);
        // restart exactly in the done cycle
        run_xfer(1, 16'h0021, 16'h0300, 70, 1'b1);
        // random runs
        for (int t = 0; t < 12; t++) begin
            run_xfer(int'($urandom % 2), int'($urandom % 16'h3000),
                     int'($urandom % 16'h3000), 20 + int'($urandom % 80), 1'b0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule